// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM that accepts a read or a write on every enabled clock edge, in any order, with no idle cycle between direction changes. Each operation is presented as an address plus control on one rising edge. Read data leaves a registered output one enabled edge later. Write data follows its address by exactly two enabled edges. A two-deep pipeline of write addresses and lane masks keeps each write lined up with its data, so the shared data bus stays busy every cycle.

A load cycle captures a full address and the operation type. Following advance cycles step a two-bit burst counter through the four words of the aligned group, in linear or interleaved order as chosen by a static order pin. Three chip selects must all be asserted for a load to do anything. A clock enable freezes the whole block. Output enable gates the bus driver without regard to the clock. The storage is a small register array of `DEPTH` words, each made of `LANES` lanes of `LANE_W` bits.

Top module: `nt_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `dq_oe` is 0 until a read completes, and every word of the array reads back as zero.
- R2: A selected read load accepted on an enabled edge drives the word on `dq_out`, with `dq_oe` high when `oe_n` is low, after the next enabled edge.
- R3: Write data on `dq_in` is taken at the second enabled edge after its address. Lane i is bits [i*LANE_W+LANE_W-1 : i*LANE_W] and is written only if `bw_n[i]` was 0 on the address edge.
- R4: A read whose address matches a write that is still waiting for its data returns the new data in the enabled lanes and the old contents in the other lanes.
- R5: A load is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. A deselected load writes nothing and leaves `dq_oe` low.
- R6: With `adv`=1 the block repeats the operation and selection of the last load and ignores `we_n` and the address. The counter goes to 1, 2, 3, 0 and the low two address bits are base+count mod 4 when `lin_order`=1 and base XOR count when `lin_order`=0.
- R7: An edge with `clk_en`=0 changes nothing. The output word and drive, the burst counter and any waiting write all hold, and a waiting write takes its data on the later enabled edge.
- R8: `dq_oe` follows `oe_n` without waiting for a clock edge: it falls at once when `oe_n` rises, and it comes back when `oe_n` falls if a read result is held.
- R9: After an enabled edge that completes a write or a deselected cycle, `dq_oe` is 0.
- R10: Any mix of reads and writes, one per enabled edge, completes with no idle cycle, and every read returns the most recent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable, 1 = edge is used |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read, on load cycles |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| bw_n | input | LANES | Per-lane write enable, active low |
| lin_order | input | 1 | Static burst order, 1 = linear, 0 = interleaved |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DW | Bus value seen by the device |
| dq_out | output | DW | Registered read word |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The hardest case to reach from the ports is a read that lands on a word whose write is still waiting for its data. The case gets harder when that write has a partial lane mask, or when clock-enable stalls hold both operations in flight over several edges. The random stimulus keeps most addresses within eight words, draws lane masks freely and drops the clock enable at random. As a result, same-address write-then-read pairs, stalled pipelines and burst advances over the same group come up thousands of times. Directed sequences first pin down the exact latency, each burst order, each chip select and the asynchronous output enable.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    // low address bits of a burst beat: linear adds, interleaved flips
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] step,
                                             input logic       linear);
        return linear ? (base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/nt_sram_burst.sv
module nt_sram_burst import nt_sram_pkg::*; #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ce2_n,
    input  logic             we_n,
    input  logic             adv,
    input  logic [LANES-1:0] bw_n,
    input  logic             lin_order,
    input  logic [AW-1:0]    addr,
    output op_kind_e         cur_kind,
    output logic [AW-1:0]    cur_addr,
    output logic [LANES-1:0] cur_be
);

    typedef struct packed {
        op_kind_e      kind;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } burst_t;

    burst_t st_d, st_q;
    logic   sel;
    logic [1:0] step;

    always_comb begin
        st_d     = st_q;
        sel      = !ce0_n && ce1 && !ce2_n;
        step     = st_q.cnt + 2'd1;
        cur_be   = ~bw_n;
        if (!adv) begin
            cur_kind = sel ? (we_n ? OP_READ : OP_WRITE) : OP_IDLE;
            cur_addr = addr;
            st_d.kind = cur_kind;
            st_d.base = addr;
            st_d.cnt  = 2'd0;
        end else begin
            cur_kind = st_q.kind;
            cur_addr = {st_q.base[AW-1:2], burst_low(st_q.base[1:0], step, lin_order)};
            st_d.cnt = step;
        end
        if (!clk_en) begin
            st_d = st_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{kind: OP_IDLE, base: '0, cnt: 2'd0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nt_sram_wpipe.sv
module nt_sram_wpipe import nt_sram_pkg::*; #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  op_kind_e         cur_kind,
    input  logic [AW-1:0]    cur_addr,
    input  logic [LANES-1:0] cur_be,
    output op_kind_e         s1_kind,
    output logic [AW-1:0]    s1_addr,
    output op_kind_e         s2_kind,
    output logic [AW-1:0]    s2_addr,
    output logic [LANES-1:0] s2_be
);

    typedef struct packed {
        op_kind_e         kind;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be;
    } stage_t;

    typedef struct packed {
        stage_t s1;
        stage_t s2;
    } pipe_t;

    pipe_t pp_d, pp_q;

    always_comb begin
        pp_d = pp_q;
        if (clk_en) begin
            pp_d.s2 = pp_q.s1;
            pp_d.s1 = '{kind: cur_kind, addr: cur_addr, be: cur_be};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q.s1 <= '{kind: OP_IDLE, addr: '0, be: '0};
            pp_q.s2 <= '{kind: OP_IDLE, addr: '0, be: '0};
        end else begin
            pp_q <= pp_d;
        end
    end

    assign s1_kind = pp_q.s1.kind;
    assign s1_addr = pp_q.s1.addr;
    assign s2_kind = pp_q.s2.kind;
    assign s2_addr = pp_q.s2.addr;
    assign s2_be   = pp_q.s2.be;

endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH = 1 << AW,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wbe,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cell_d [DEPTH];
        logic [LANE_W-1:0] cell_q [DEPTH];

        always_comb begin
            cell_d = cell_q;
            if (we && wbe[l]) begin
                cell_d[waddr] = wdata[l*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    cell_q[i] <= '0;
                end
            end else begin
                cell_q <= cell_d;
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = cell_q[raddr];
    end

endmodule

// File: rtl/nt_sram_rdout.sv
module nt_sram_rdout #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             rd_req,
    input  logic [DW-1:0]    arr_word,
    input  logic             fwd_hit,
    input  logic [LANES-1:0] fwd_be,
    input  logic [DW-1:0]    fwd_data,
    output logic [DW-1:0]    word_q,
    output logic             drive_q
);

    typedef struct packed {
        logic          drive;
        logic [DW-1:0] word;
    } out_t;

    out_t o_d, o_q;
    logic [DW-1:0] merged;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            merged[l*LANE_W +: LANE_W] = (fwd_hit && fwd_be[l]) ?
                fwd_data[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
        end
        o_d = o_q;
        if (clk_en) begin
            o_d.drive = rd_req;
            if (rd_req) begin
                o_d.word = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{drive: 1'b0, word: '0};
        end else begin
            o_q <= o_d;
        end
    end

    assign word_q  = o_q.word;
    assign drive_q = o_q.drive;

endmodule

// File: rtl/nt_sram.sv
module nt_sram import nt_sram_pkg::*; #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ce2_n,
    input  logic             we_n,
    input  logic             adv,
    input  logic [LANES-1:0] bw_n,
    input  logic             lin_order,
    input  logic [AW-1:0]    addr,
    input  logic             oe_n,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    op_kind_e         cur_kind;
    logic [AW-1:0]    cur_addr;
    logic [LANES-1:0] cur_be;
    op_kind_e         s1_kind;
    logic [AW-1:0]    s1_addr;
    op_kind_e         s2_kind;
    logic [AW-1:0]    s2_addr;
    logic [LANES-1:0] s2_be;
    logic             arr_we;
    logic [DW-1:0]    arr_word;
    logic             fwd_hit;
    logic             rd_drive;

    nt_sram_burst #(.AW(AW), .LANES(LANES)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .ce0_n    (ce0_n),
        .ce1      (ce1),
        .ce2_n    (ce2_n),
        .we_n     (we_n),
        .adv      (adv),
        .bw_n     (bw_n),
        .lin_order(lin_order),
        .addr     (addr),
        .cur_kind (cur_kind),
        .cur_addr (cur_addr),
        .cur_be   (cur_be)
    );

    nt_sram_wpipe #(.AW(AW), .LANES(LANES)) u_wpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .cur_kind(cur_kind),
        .cur_addr(cur_addr),
        .cur_be  (cur_be),
        .s1_kind (s1_kind),
        .s1_addr (s1_addr),
        .s2_kind (s2_kind),
        .s2_addr (s2_addr),
        .s2_be   (s2_be)
    );

    // the oldest stage owns this cycle's bus data when it is a write
    assign arr_we  = clk_en && (s2_kind == OP_WRITE);
    assign fwd_hit = (s2_kind == OP_WRITE) && (s2_addr == s1_addr);

    nt_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (arr_we),
        .waddr(s2_addr),
        .wbe  (s2_be),
        .wdata(dq_in),
        .raddr(s1_addr),
        .rdata(arr_word)
    );

    nt_sram_rdout #(.LANES(LANES), .LANE_W(LANE_W)) u_rdout (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .rd_req  (s1_kind == OP_READ),
        .arr_word(arr_word),
        .fwd_hit (fwd_hit),
        .fwd_be  (s2_be),
        .fwd_data(dq_in),
        .word_q  (dq_out),
        .drive_q (rd_drive)
    );

    assign dq_oe = rd_drive && !oe_n;

endmodule

// File: rtl/nt_sram_chk.sv
module nt_sram_chk import nt_sram_pkg::*; #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          adv,
    input logic          ce0_n,
    input logic          ce1,
    input logic          ce2_n,
    input logic [DW-1:0] dq_out,
    input logic          rd_drive,
    input op_kind_e      s1_kind
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !rd_drive);

    assert_read_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s1_kind == OP_READ) |=> rd_drive);

    assert_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && !(!ce0_n && ce1 && !ce2_n)) |=> (s1_kind == OP_IDLE));

    assert_stall_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(dq_out) && $stable(rd_drive)));

    assert_stall_pipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(s1_kind));

    assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s1_kind == OP_WRITE) |=> !rd_drive);

endmodule

bind nt_sram nt_sram_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .adv     (adv),
    .ce0_n   (ce0_n),
    .ce1     (ce1),
    .ce2_n   (ce2_n),
    .dq_out  (dq_out),
    .rd_drive(rd_drive),
    .s1_kind (s1_kind)
);

// File: tb/nt_sram_bench.sv
`timescale 1ns/1ps
module nt_sram_bench;

    localparam int AW     = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam int DEPTH  = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clk_en;
    logic             ce0_n, ce1, ce2_n;
    logic             we_n, adv;
    logic [LANES-1:0] bw_n;
    logic             lin_order;
    logic [AW-1:0]    addr;
    logic             oe_n;
    logic [DW-1:0]    dq_in;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;

    always #5 clk = ~clk;

    nt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_nt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce0_n(ce0_n), .ce1(ce1),
        .ce2_n(ce2_n), .we_n(we_n), .adv(adv), .bw_n(bw_n),
        .lin_order(lin_order), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int    nvec  = 0;
    int    nfail = 0;
    string cur_tag = "R1";

    // expected-behaviour state: 0 idle, 1 read, 2 write
    logic [DW-1:0]    m_mem [DEPTH];
    int               m_kind;
    logic [AW-1:0]    m_base;
    logic [1:0]       m_cnt;
    int               p1_k, p2_k;
    logic [AW-1:0]    p1_a, p2_a;
    logic [LANES-1:0] p1_be, p2_be;
    logic             exp_drv;
    logic [DW-1:0]    exp_word;

    function automatic logic [1:0] beat_low(input logic [1:0] b, input logic [1:0] c,
                                            input logic lin);
        return lin ? 2'(b + c) : (b ^ c);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_kind = 0; m_base = '0; m_cnt = 2'd0;
        p1_k = 0; p2_k = 0; p1_a = '0; p2_a = '0; p1_be = '0; p2_be = '0;
        exp_drv = 1'b0; exp_word = '0;
    endtask

    task automatic model_edge();
        logic sel;
        logic [AW-1:0] ea;
        int k;
        if (p2_k == 2) begin
            for (int l = 0; l < LANES; l++)
                if (p2_be[l]) m_mem[p2_a][l*LANE_W +: LANE_W] = dq_in[l*LANE_W +: LANE_W];
        end
        if (p1_k == 1) begin
            exp_drv  = 1'b1;
            exp_word = m_mem[p1_a];
        end else begin
            exp_drv = 1'b0;
        end
        p2_k = p1_k; p2_a = p1_a; p2_be = p1_be;
        sel = !ce0_n && ce1 && !ce2_n;
        if (!adv) begin
            k = sel ? (we_n ? 1 : 2) : 0;
            m_kind = k; m_base = addr; m_cnt = 2'd0; ea = addr;
        end else begin
            m_cnt = m_cnt + 2'd1;
            k = m_kind;
            ea = {m_base[AW-1:2], beat_low(m_base[1:0], m_cnt, lin_order)};
        end
        p1_k = k; p1_a = ea; p1_be = ~bw_n;
    endtask

    task automatic compare();
        logic e_oe;
        e_oe = exp_drv && !oe_n;
        nvec++;
        if (dq_oe !== e_oe) begin
            nfail++;
            $display("FAIL %s dq_oe actual=%b expected=%b at %0t", cur_tag, dq_oe, e_oe, $time);
        end else if (e_oe && dq_out !== exp_word) begin
            nfail++;
            $display("FAIL %s dq_out actual=%h expected=%h at %0t", cur_tag, dq_out, exp_word, $time);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        if (clk_en && rst_n) model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic op(input bit en, input bit s, input bit w, input bit a,
                      input int ad, input logic [LANES-1:0] bw, input logic [DW-1:0] d);
        clk_en = en;
        {ce0_n, ce1, ce2_n} = s ? 3'b010 : 3'b110;
        we_n = ~w; adv = a; addr = AW'(ad); bw_n = bw; dq_in = d;
        cycle();
    endtask

    task automatic idle(input logic [DW-1:0] d);
        op(1'b1, 1'b0, 1'b0, 1'b0, 0, '1, d);
    endtask

    task automatic check_oe(input logic e);
        nvec++;
        if (dq_oe !== e) begin
            nfail++;
            $display("FAIL R8 dq_oe actual=%b expected=%b at %0t", dq_oe, e, $time);
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    initial begin : watchdog
        #1_500_000;
        nfail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst_n = 1'b0; clk_en = 1'b1; {ce0_n, ce1, ce2_n} = 3'b110;
        we_n = 1'b1; adv = 1'b0; bw_n = '1; lin_order = 1'b0;
        addr = '0; oe_n = 1'b0; dq_in = '0;
        model_reset();
        // R1: undriven while in reset
        repeat (3) cycle();
        rst_n = 1'b1;
        cur_tag = "R1";
        idle('0);
        op(1, 1, 0, 0, 7, 4'b0000, '0);      // R1: read of a reset word gives zero
        idle('0); idle('0);

        // R2 / R3: full write, then read with exact latency
        cur_tag = "R3";
        op(1, 1, 1, 0, 5, 4'b0000, '0);
        idle('0);
        idle(36'h1_2345_6789);
        cur_tag = "R2";
        op(1, 1, 0, 0, 5, 4'b0000, '0);
        idle('0);
        cur_tag = "R3";                       // lanes 1 and 3 only
        op(1, 1, 1, 0, 5, 4'b0101, '0);
        idle('0);
        idle(36'hF_EDCB_A987);
        op(1, 1, 0, 0, 5, 4'b1111, '0);
        idle('0);

        // R4: read right behind a same-address partial write
        cur_tag = "R4";
        op(1, 1, 1, 0, 9, 4'b0000, '0);
        op(1, 1, 1, 0, 9, 4'b1001, '0);
        op(1, 1, 0, 0, 9, 4'b1111, 36'hA_AAAA_AAAA);
        idle(36'h5_5555_5555);
        idle('0);

        // R6: bursts in both orders, we_n ignored on advance
        for (int w = 0; w < 8; w++) begin
            op(1, 1, 1, 0, 16 + w, 4'b0000, '0);
        end
        for (int w = 0; w < 8; w++) begin
            op(1, 0, 0, 0, 0, 4'b1111, rnd_word());
        end
        for (int o = 0; o < 2; o++) begin
            lin_order = o[0];
            cur_tag = "R6";
            op(1, 1, 0, 0, 17, 4'b1111, rnd_word());
            op(1, 1, 1, 1, 0, 4'b1111, rnd_word());
            op(1, 0, 1, 1, 0, 4'b1111, rnd_word());
            op(1, 1, 0, 1, 0, 4'b1111, rnd_word());
            op(1, 1, 1, 0, 22, 4'b0000, rnd_word());
            op(1, 1, 0, 1, 0, 4'b0000, rnd_word());
            op(1, 1, 0, 1, 0, 4'b0000, rnd_word());
            op(1, 1, 0, 1, 0, 4'b0000, rnd_word());
            idle(rnd_word()); idle(rnd_word());
            for (int w = 20; w < 24; w++) op(1, 1, 0, 0, w, 4'b1111, '0);
            idle('0);
        end

        // R7: stall with a read result held and a write waiting
        cur_tag = "R7";
        op(1, 1, 1, 0, 30, 4'b0000, '0);
        op(1, 1, 0, 0, 30, 4'b1111, '0);
        op(0, 1, 1, 0, 3, 4'b0000, 36'h0_DEAD_BEEF);
        op(0, 0, 1, 1, 4, 4'b0000, 36'h0_BAD0_BAD0);
        op(1, 1, 0, 0, 30, 4'b1111, 36'h3_1415_9265);
        op(0, 1, 1, 0, 2, 4'b0000, 36'h0);
        op(1, 1, 0, 0, 30, 4'b1111, '0);
        idle('0);

        // R5: each chip select on its own blocks a write
        cur_tag = "R5";
        for (int c = 0; c < 3; c++) begin
            clk_en = 1; we_n = 0; adv = 0; addr = AW'(40); bw_n = '0; dq_in = '0;
            {ce0_n, ce1, ce2_n} = 3'b010 ^ (3'b100 >> c);
            cycle();
            idle('0);
            idle(36'h7_7777_7777);
        end
        op(1, 1, 0, 0, 40, 4'b1111, '0);
        idle('0);

        // R9: write and deselect cycles leave the bus undriven
        cur_tag = "R9";
        op(1, 1, 0, 0, 5, 4'b1111, '0);
        op(1, 1, 1, 0, 6, 4'b0000, '0);
        op(1, 0, 0, 0, 6, 4'b1111, '0);
        idle(rnd_word());
        idle('0);

        // R8: output enable acts between edges
        cur_tag = "R8";
        op(1, 1, 0, 0, 5, 4'b1111, '0);
        idle('0);
        #1 oe_n = 1'b1; #1 check_oe(1'b0);
        oe_n = 1'b0; #1 check_oe(1'b1);
        @(negedge clk);

        // R10: random mix, narrow address range to force collisions
        cur_tag = "R10";
        for (int ph = 0; ph < 2; ph++) begin
            lin_order = ph[0];
            for (int n = 0; n < 4000; n++) begin
                int r;
                clk_en = ($urandom_range(0, 9) != 0);
                r = $urandom_range(0, 19);
                {ce0_n, ce1, ce2_n} = (r == 0) ? 3'b110 : (r == 1) ? 3'b000 :
                                      (r == 2) ? 3'b011 : 3'b010;
                we_n = $urandom_range(0, 1);
                adv  = ($urandom_range(0, 9) < 4);
                addr = ($urandom_range(0, 7) == 0) ? AW'($urandom()) : AW'($urandom_range(0, 7));
                bw_n = LANES'($urandom());
                oe_n = ($urandom_range(0, 9) == 0);
                dq_in = rnd_word();
                cycle();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule